// File: doc/BRIEF.md
# Transmit Holding Queue

This block buffers up to 24 bytes written by a processor on their way to a transmitter shift register. A byte written on the write port joins the tail of the queue. The oldest byte is handed to the shift register whenever the shift register reports that it is idle. Serialization and baud timing sit outside this block. Here the shift register appears only as an idle input and a load strobe with its data.

The block reports its state at every cycle. It gives a live count of held characters, a ready flag while space remains, and an empty flag that also takes the shift register into account. A threshold flag compares the number of free slots against a programmed level. The ready and threshold flags can each be enabled onto a single interrupt line.

Top module: `tx_hold_queue`

## Requirements
- R1: After reset the count is 0 and the ready flag is 1, and no load is issued while the queue is empty.
- R2: Bytes reach `ld_data` in the exact order in which they were accepted.
- R3: `ld` is high exactly when `sr_idle` is 1 and the count is nonzero. On that cycle the head byte leaves the queue at the clock edge.
- R4: A write with count below 24 is accepted, and the count rises by one unless a load happens in the same cycle.
- R5: A write while the count is 24 and no load is happening is dropped. The count stays 24, and the dropped byte never appears on `ld_data`.
- R6: A write while the count is 24 in the same cycle as a load is accepted. The count stays 24, and the new byte becomes the last entry.
- R7: `ready` is 1 exactly when the count is below 24.
- R8: `tx_empty` is 1 exactly when the count is 0 and `sr_idle` is 1.
- R9: `count` always equals the number of held bytes and never exceeds 24.
- R10: `thr_hit` is 1 exactly when the free slots (24 minus the count) are greater than or equal to `thr_level`.
- R11: `irq` equals (`irq_rdy_en` AND `ready`) OR (`irq_thr_en` AND `thr_hit`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Processor write strobe |
| wr_data | input | 8 | Byte to queue |
| sr_idle | input | 1 | Shift register can take a byte |
| ld | output | 1 | Head byte transferred to the shift register this cycle |
| ld_data | output | 8 | Head byte |
| thr_level | input | 5 | Programmed free-slot threshold |
| irq_rdy_en | input | 1 | Enable ready flag onto irq |
| irq_thr_en | input | 1 | Enable threshold flag onto irq |
| count | output | 5 | Held characters, 0 to 24 |
| ready | output | 1 | At least one slot free |
| tx_empty | output | 1 | Queue and shift register both empty |
| thr_hit | output | 1 | Free slots at or above the threshold |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that `sr_idle` is a clean level held stable between clock edges. They also assume that the shift register takes the byte on every cycle in which `ld` is high, with no further acknowledge. The bench drives every input shortly after the falling edge and holds it through the next rising edge. It varies `sr_idle` freely, so loads happen whenever the rule allows them and never when it does not. The threshold level stays within 0 to 25, which covers the always-true and never-true ends of the compare.

// File: rtl/tx_hold_queue.sv
module tx_hold_queue #(
  parameter int DEPTH = 24,
  parameter int DW    = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          sr_idle,
  output logic          ld,
  output logic [DW-1:0] ld_data,
  input  logic [CW-1:0] thr_level,
  input  logic          irq_rdy_en,
  input  logic          irq_thr_en,
  output logic [CW-1:0] count,
  output logic          ready,
  output logic          tx_empty,
  output logic          thr_hit,
  output logic          irq
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic          push;

  assign ready    = count != FULL;
  assign ld       = sr_idle && (count != '0);
  assign push     = wr_en && (ready || ld);
  assign ld_data  = mem[rd_ptr];
  assign tx_empty = sr_idle && (count == '0);
  assign thr_hit  = (FULL - count) >= thr_level;
  assign irq      = (irq_rdy_en && ready) || (irq_thr_en && thr_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (ld)   rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (push && !ld)      count <= count + 1'b1;
      else if (ld && !push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end
endmodule

// File: rtl/tx_hold_queue_chk.sv
module tx_hold_queue_chk #(
  parameter int DEPTH = 24,
  parameter int DW    = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [DW-1:0] wr_data,
  input logic          sr_idle,
  input logic          ld,
  input logic [CW-1:0] count,
  input logic          ready,
  input logic          tx_empty
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  AST_COUNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL); // R9
  AST_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_idle |-> !ld); // R3
  AST_NO_LOAD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> !ld); // R3
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (count == FULL && wr_en && !ld) |=> count == FULL); // R5
  AST_FULL_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (count == FULL && wr_en && ld) |=> count == FULL); // R6
  AST_READY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> count == FULL); // R7
  AST_EMPTY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> (count == '0 && sr_idle)); // R8
  AST_WRITE_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ld && count != FULL) |=> count == $past(count) + 1'b1); // R4
endmodule

bind tx_hold_queue tx_hold_queue_chk #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .sr_idle(sr_idle), .ld(ld), .count(count), .ready(ready), .tx_empty(tx_empty)
);

// File: tb/sim_tx_hold_queue.sv
module sim_tx_hold_queue;
  localparam int DEPTH = 24;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       sr_idle = 1'b0;
  logic [4:0] thr_level = '0;
  logic       irq_rdy_en = 1'b0, irq_thr_en = 1'b0;
  logic       ld, ready, tx_empty, thr_hit, irq;
  logic [7:0] ld_data;
  logic [4:0] count;

  int checks = 0;
  int errors = 0;
  logic [7:0] q[$];

  always #2 clk = ~clk;

  tx_hold_queue u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .sr_idle(sr_idle), .ld(ld), .ld_data(ld_data), .thr_level(thr_level),
    .irq_rdy_en(irq_rdy_en), .irq_thr_en(irq_thr_en), .count(count),
    .ready(ready), .tx_empty(tx_empty), .thr_hit(thr_hit), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit w, input logic [7:0] d, input bit idle);
    bit e_ld, e_rdy, e_thr, acc;
    int sz;
    wr_en = w; wr_data = d; sr_idle = idle;
    #1;
    sz    = q.size();
    e_ld  = idle && sz > 0;
    e_rdy = sz < DEPTH;
    e_thr = (DEPTH - sz) >= int'(thr_level);
    acc   = w && (e_rdy || e_ld);
    chk(int'(count) == sz, "R9 count", count, sz);
    chk(ready == e_rdy, "R7 ready", ready, e_rdy);
    chk(ld == e_ld, "R3 load", ld, e_ld);
    chk(tx_empty == (sz == 0 && idle), "R8 tx_empty", tx_empty, sz == 0 && idle);
    chk(thr_hit == e_thr, "R10 thr_hit", thr_hit, e_thr);
    chk(irq == ((irq_rdy_en && e_rdy) || (irq_thr_en && e_thr)), "R11 irq", irq,
        (irq_rdy_en && e_rdy) || (irq_thr_en && e_thr));
    if (e_ld) chk(ld_data == q[0], "R2 order", ld_data, q[0]);
    @(posedge clk);
    if (e_ld) void'(q.pop_front());
    if (acc) q.push_back(d);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(count == 0, "R1 reset count", count, 0);
    chk(ready == 1'b1, "R1 reset ready", ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    step(0, 8'h00, 1);
    // R4 R5 R10: fill with busy shift register, overflow attempts dropped
    thr_level = 5'd6; irq_thr_en = 1'b1;
    for (int i = 0; i < 30; i++) step(1, 8'(8'h10 + i), 0);
    chk(count == 24, "R5 full hold", count, 24);
    irq_rdy_en = 1'b1; irq_thr_en = 1'b0;
    step(0, 8'h00, 0);
    // R6: write into full queue while loading
    step(1, 8'hA5, 1);
    chk(count == 24, "R6 full swap", count, 24);
    // drain, R2 order and dropped bytes never appear
    thr_level = 5'd25;
    for (int i = 0; i < 30; i++) step(0, 8'h00, 1);
    chk(count == 0, "R9 drained", count, 0);
    // mixed traffic with various levels
    for (int i = 0; i < 2000; i++) begin
      if (i % 100 == 0) begin
        thr_level  = 5'($urandom_range(0, 25));
        irq_rdy_en = 1'($urandom);
        irq_thr_en = 1'($urandom);
      end
      if ((i / 300) % 2 == 0)
        step(($urandom_range(0, 3) != 0), 8'($urandom), ($urandom_range(0, 3) == 0));
      else
        step(($urandom_range(0, 3) == 0), 8'($urandom), ($urandom_range(0, 3) != 0));
    end
    for (int i = 0; i < 30; i++) step(0, 8'h00, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule